// File: doc/BRIEF.md
# Flash Blank-Check Command Engine

This block is the command decoder and write state machine of a parallel NOR flash, cut down to one job: confirming that an array block is fully erased. A host writes bus cycles (address plus data). A setup byte followed by a confirm byte aimed at the same block starts a scan. The scan reads every word of that block from a small internal array model, one word per clock. Progress and outcome are reported through an 8-bit status byte. While the device is outside array mode, a bus read at any address returns that status byte.

A word counts as erased when every bit is 1. A single 0 bit anywhere in the addressed block marks the block as not blank. A separate load port fills the array model so that blocks can be blank or programmed. The active-low reset aborts any scan and puts the engine back in array-read mode with clean status.

The engine has four states. FS_ARRAY is array-read mode. FS_SETUP waits for the confirm cycle. FS_SCAN walks the block. FS_STATUS is status-read mode.

Its transitions are:
- ARM: FS_ARRAY or FS_STATUS to FS_SETUP, on a setup write.
- LAUNCH: FS_SETUP to FS_SCAN, on a matching confirm.
- REJECT: FS_SETUP to FS_STATUS, on any other write.
- FINISH: FS_SCAN to FS_STATUS, after the last word.
- LEAVE: FS_STATUS to FS_ARRAY, on a read-array write.
- ABORT: any state to FS_ARRAY, on reset.

Top module: `flash_blank_check`

## Requirements
- R1: After reset the engine is in array mode: reads return the array word at the bus address, and both error bits are clear. The status byte has bit 7 = ready, bit 5 = blank-check failure and bit 4 = command-sequence error, with all other bits 0.
- R2: A write of 0xBC to any address of a block, followed by a write of 0xD0 to any address of the same block, starts a scan. During the scan, status bit 7 reads 0 for exactly 2^BLK_AW cycles after the confirm edge, and then reads 1.
- R3: In the setup, scan and status states, a read at any address returns the status byte. In array mode, a read returns the array word.
- R4: After a scan, status bit 5 is 1 if and only if some word of the addressed block has a 0 bit. Words in other blocks have no effect on the result.
- R5: If the write following 0xBC has data other than 0xD0, or is aimed at a different block, no scan runs. The engine goes to status mode with bits 7, 5 and 4 all set (status 0xB0).
- R6: Writes made during a scan are ignored. Busy lasts the full scan length, and the result depends only on the block being scanned.
- R7: After a scan the engine stays in status mode until a command is written. A write of 0xFF returns it to array mode.
- R8: A write of 0x50 outside setup and scan clears status bits 5 and 4 and leaves the current mode unchanged.
- R9: Driving rst_n low during a scan aborts it: afterwards reads return array data and both error bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and abort |
| bus_we | input | 1 | Bus write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Word address for both reads and writes |
| bus_wdata | input | DATA_W | Write data; the command byte is held in the low 8 bits |
| bus_rdata | output | DATA_W | Read data: the array word or the status byte |
| ld_we | input | 1 | Load strobe for the array model |
| ld_addr | input | ADDR_W | Address for the load port |
| ld_data | input | DATA_W | Data for the load port |

## Verification
On every cycle, the assertions check the following:
- the scan keeps running until its last word and then finishes in status mode;
- a rejected confirm lands in status mode with the sequence error set;
- the latched block does not change during a scan;
- a non-erased word always raises the failure bit;
- a clear command drops both error bits.

Other behaviours need the bench's scenarios. These are the exact busy length, the pass/fail verdict for every block and every programmed-word position, and isolation from neighbouring blocks. The same goes for writes being ignored mid-scan, status mode persisting, and the abort on reset.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
    typedef enum logic [1:0] {
        FS_ARRAY  = 2'd0,
        FS_SETUP  = 2'd1,
        FS_SCAN   = 2'd2,
        FS_STATUS = 2'd3
    } fbc_state_t;

    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] CMD_SETUP   = 8'hBC;
    localparam logic [CMD_W-1:0] CMD_CONFIRM = 8'hD0;
    localparam logic [CMD_W-1:0] CMD_CLEAR   = 8'h50;
    localparam logic [CMD_W-1:0] CMD_ARRAY   = 8'hFF;

    localparam int SR_READY = 7;
    localparam int SR_BLANK = 5;
    localparam int SR_SEQ   = 4;
endpackage

// File: rtl/fbc_array.sv
module fbc_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int NWORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (ld_we) mem[ld_addr] <= ld_data;
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/fbc_decode.sv
module fbc_decode #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] wdata,
    output logic              is_setup,
    output logic              is_confirm,
    output logic              is_clear,
    output logic              is_array
);
    import fbc_pkg::*;

    logic [CMD_W-1:0] cmd;

    assign cmd        = wdata[CMD_W-1:0];
    assign is_setup   = (cmd == CMD_SETUP);
    assign is_confirm = (cmd == CMD_CONFIRM);
    assign is_clear   = (cmd == CMD_CLEAR);
    assign is_array   = (cmd == CMD_ARRAY);
endmodule

// File: rtl/fbc_scan.sv
module fbc_scan #(
    parameter int BLK_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    output logic [BLK_AW-1:0] idx,
    output logic              last
);
    localparam logic [BLK_AW-1:0] LAST_IDX = {BLK_AW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx <= '0;
        else if (start) idx <= '0;
        else if (run)   idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && !last) |=> (idx == $past(idx) + 1'b1)); // R2
endmodule

// File: rtl/flash_blank_check.sv
module flash_blank_check #(
    parameter int DATA_W  = 8,
    parameter int BLK_AW  = 3,
    parameter int NBLK_AW = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [NBLK_AW+BLK_AW-1:0]    bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic                         ld_we,
    input  logic [NBLK_AW+BLK_AW-1:0]    ld_addr,
    input  logic [DATA_W-1:0]            ld_data
);
    import fbc_pkg::*;

    localparam int ADDR_W = NBLK_AW + BLK_AW;

    fbc_state_t         state, nxt;
    logic [NBLK_AW-1:0] blk_q;
    logic               err_blank, err_seq;
    logic               is_setup, is_confirm, is_clear, is_array;
    logic [BLK_AW-1:0]  idx;
    logic               last;
    logic               scan_start, scan_run, confirm_ok, word_bad;
    logic [DATA_W-1:0]  arr_bus, arr_scan, status;
    logic [NBLK_AW-1:0] bus_blk;

    assign bus_blk = bus_addr[ADDR_W-1:BLK_AW];

    fbc_decode #(.DATA_W(DATA_W)) u_dec (
        .wdata(bus_wdata), .is_setup(is_setup), .is_confirm(is_confirm),
        .is_clear(is_clear), .is_array(is_array)
    );

    fbc_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr_a(bus_addr), .rd_data_a(arr_bus),
        .rd_addr_b({blk_q, idx}), .rd_data_b(arr_scan)
    );

    fbc_scan #(.BLK_AW(BLK_AW)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .run(scan_run),
        .idx(idx), .last(last)
    );

    assign confirm_ok = is_confirm && (bus_blk == blk_q);
    assign scan_start = (state == FS_SETUP) && bus_we && confirm_ok;
    assign scan_run   = (state == FS_SCAN);
    assign word_bad   = (arr_scan != {DATA_W{1'b1}});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_ARRAY;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            FS_ARRAY, FS_STATUS: begin
                if (bus_we && is_setup)      nxt = FS_SETUP;   // ARM
                else if (bus_we && is_array) nxt = FS_ARRAY;   // LEAVE
            end
            FS_SETUP: begin
                if (bus_we) nxt = confirm_ok ? FS_SCAN : FS_STATUS; // LAUNCH / REJECT
            end
            FS_SCAN: begin
                if (last) nxt = FS_STATUS;                     // FINISH
            end
        endcase
    end

    // Block latch and error bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q     <= '0;
            err_blank <= 1'b0;
            err_seq   <= 1'b0;
        end else begin
            unique case (state)
                FS_ARRAY, FS_STATUS: begin
                    if (bus_we && is_setup) blk_q <= bus_blk;
                    if (bus_we && is_clear) begin
                        err_blank <= 1'b0;
                        err_seq   <= 1'b0;
                    end
                end
                FS_SETUP: begin
                    if (bus_we && !confirm_ok) begin
                        err_blank <= 1'b1;
                        err_seq   <= 1'b1;
                    end
                end
                FS_SCAN: begin
                    if (word_bad) err_blank <= 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        status           = '0;
        status[SR_READY] = (state != FS_SCAN);
        status[SR_BLANK] = err_blank;
        status[SR_SEQ]   = err_seq;
        bus_rdata        = (state == FS_ARRAY) ? arr_bus : status;
    end

    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_SCAN && !last) |=> (state == FS_SCAN)); // R2
    AST_SCAN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_SCAN && last) |=> (state == FS_STATUS && bus_rdata[SR_READY])); // R2
    AST_BAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_SCAN && word_bad) |=> err_blank); // R4
    AST_SEQ_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_SETUP && bus_we && !confirm_ok) |=> (state == FS_STATUS && err_seq && err_blank)); // R5
    AST_BLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_SCAN) |=> $stable(blk_q)); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FS_ARRAY || state == FS_STATUS) && bus_we && is_clear) |=> (!err_blank && !err_seq)); // R8
endmodule

// File: tb/sim_flash_blank_check.sv
`timescale 1ns/1ps
module sim_flash_blank_check;
    localparam int DW = 8, BAW = 3, NBAW = 2;
    localparam int AW = BAW + NBAW;
    localparam int NW = 1 << AW, BW = 1 << BAW, NB = 1 << NBAW;

    logic clk = 0, rst_n = 0, bus_we = 0, ld_we = 0;
    logic [AW-1:0] bus_addr = '0, ld_addr = '0;
    logic [DW-1:0] bus_wdata = '0, ld_data = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] model [NW];
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    flash_blank_check #(.DATA_W(DW), .BLK_AW(BAW), .NBLK_AW(NBAW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1; bus_addr = a[AW-1:0]; bus_wdata = d[DW-1:0];
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = a[AW-1:0];
        #0.5;
        d = int'(bus_rdata);
    endtask

    task automatic load(input int a, input int d);
        @(negedge clk);
        ld_we = 1; ld_addr = a[AW-1:0]; ld_data = d[DW-1:0];
        model[a] = d[DW-1:0];
        @(negedge clk);
        ld_we = 0;
    endtask

    // Counts busy cycles at negedges, starting right after the confirm write
    task automatic busy_len(output int n);
        int v;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            rd(0, v);
            if (v[7]) break;
            n++;
            @(negedge clk);
        end
    endtask

    function automatic bit blk_fails(input int b);
        for (int w = 0; w < BW; w++)
            if (model[b*BW + w] != 8'hFF) return 1;
        return 0;
    endfunction

    initial begin : watchdog
        #(5.0 * 150000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, n, expst;
        for (int i = 0; i < NW; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: array mode after reset
        for (int i = 0; i < NW; i++) load(i, (i * 37 + 11) & 8'hFF);
        for (int i = 0; i < NW; i++) begin
            rd(i, v);
            chk(v == model[i], "R1 reset array read", v, model[i]);
        end

        // R4 / R2 sweep: each block, each programmed-word position, plus blank
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p <= BW; p++) begin
                for (int i = 0; i < NW; i++)
                    load(i, (i / BW == b) ? ((i % BW == p) ? (8'hFF & ~(1 << (p % 8))) : 8'hFF) : 8'h00);
                wr(b*BW, 8'h50);
                wr(b*BW + (p % BW), 8'hBC);
                wr(b*BW + ((p + 3) % BW), 8'hD0);
                busy_len(n);
                chk(n == BW, "R2 busy length", n, BW);
                expst = 8'h80 | (blk_fails(b) ? 8'h20 : 0);
                rd((b * BW + 5) % NW, v);
                chk(v == expst, "R4 blank result", v, expst);
                wr(0, 8'hFF);
            end
        end

        // R3: setup state reads return status
        for (int i = 0; i < NW; i++) load(i, 8'hFF);
        wr(0, 8'h50);
        wr(9, 8'hBC);
        rd(20, v);
        chk(v == 8'h80, "R3 setup reads status", v, 8'h80);
        wr(12, 8'hD0);
        rd(3, v);
        chk(v == 8'h00, "R3 scan reads busy status", v, 8'h00);
        busy_len(n);
        // R7: stays in status mode
        repeat (5) @(negedge clk);
        rd(2, v);
        chk(v == 8'h80, "R7 status persists", v, 8'h80);
        wr(0, 8'hFF);
        load(2, 8'h5A);
        rd(2, v);
        chk(v == 8'h5A, "R7 read-array returns data", v, 8'h5A);

        // R5: wrong data and wrong block
        wr(8, 8'hBC);
        wr(8, 8'h20);
        rd(0, v);
        chk(v == 8'hB0, "R5 wrong confirm data", v, 8'hB0);
        wr(0, 8'h50);
        rd(0, v);
        chk(v == 8'h80, "R8 clear in status mode", v, 8'h80);
        wr(8, 8'hBC);
        wr(16, 8'hD0);
        rd(8, v);
        chk(v == 8'hB0, "R5 wrong confirm block", v, 8'hB0);
        // R8: clear in array mode keeps array mode
        wr(0, 8'hFF);
        wr(0, 8'h50);
        rd(2, v);
        chk(v == 8'h5A, "R8 clear keeps array mode", v, 8'h5A);

        // R6: writes during a scan ignored (block 3 blank, block 0 not)
        wr(24, 8'hBC);
        wr(24, 8'hD0);
        wr(2, 8'h50);
        wr(2, 8'hBC);
        wr(2, 8'hFF);
        busy_len(n);
        chk(n == BW - 6, "R6 busy unaffected by writes", n, BW - 6);
        rd(0, v);
        chk(v == 8'h80, "R6 result unaffected", v, 8'h80);

        // R9: abort mid-scan
        wr(0, 8'hBC);
        wr(1, 8'hD0);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rd(2, v);
        chk(v == 8'h5A, "R9 abort returns array mode", v, 8'h5A);
        wr(24, 8'hBC);
        wr(24, 8'hD0);
        busy_len(n);
        rd(0, v);
        chk(v == 8'h80, "R9 errors cleared after abort", v, 8'h80);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule